// File: doc/BRIEF.md
# Persistence-Aware Cache Tag Directory

This block is the tag directory of an eight-way set-associative cache. It holds no data, only each line's tag, valid bit, streaming mark, persisting mark, age counter and recency rank. It is built for memory traffic where some data is reused many times and other data is touched once. Every lookup carries a line address and an access property (normal, streaming or persisting). The block answers hit or miss. On a miss it picks a victim way and installs the new tag there, all in the same cycle.

A programmable number of the lowest-numbered ways in every set is held back for persisting lines. Persisting misses allocate inside that region. Normal and streaming misses may only use a held-back way while no persisting line sits in it. Streaming lines are the first to be thrown out. The persisting mark can be removed in three ways: a normal access to the line, a global clear command, or the line's age counter running out under a periodic tick. A disable input for a shared multi-tenant setup shrinks the reserved region to nothing.

Top module: `persist_dir`

## Requirements
- R1: A lookup presented with `reqValid` high at a clock edge is answered after that edge: `rspValid` is high for exactly one cycle, with `rspHit` and `rspWay` valid alongside it. Without a lookup, `rspValid` and `rspHit` are low, including after reset.
- R2: A hit returns the way that holds the matching tag. A miss returns the victim way, which then holds the new tag, so that a lookup of the same address in the next cycle hits in that way.
- R3: The reserved region is ways 0 up to R-1, where R is `resvWays` (0 to 7) or 0 while `tenantDisable` is high. A persisting miss (`reqProp`=2'b10) with R>0 picks its victim only inside the reserved region.
- R4: A normal or streaming miss never evicts a persisting line that sits in a reserved way. It may take a reserved way that holds no persisting line.
- R5: Among the allowed ways, the victim is the lowest-indexed invalid way if there is one. Otherwise it is chosen from streaming lines first, then normal lines, then persisting lines, taking the least recently accessed line within that class.
- R6: When the reserved region is full of persisting lines, a persisting miss evicts the least recently accessed of them.
- R7: A hit with the normal property (`reqProp`=2'b00, and 2'b11 is treated the same) clears both the persisting and the streaming mark of the line.
- R8: `persistClear` clears the persisting mark of every line at that edge. It overrides a mark that a lookup in the same cycle would set.
- R9: Every access reloads the line's age to 15. Each `ageTick` decrements the age of every persisting line that is not being accessed in that cycle. A persisting line whose age reaches zero loses its persisting mark.
- R10: While `tenantDisable` is high, the reserved region is empty whatever the value of `resvWays`, so a persisting miss may pick any way.
- R11: A persisting hit or fill (2'b10) sets the persisting mark and clears the streaming mark. A streaming fill (2'b01) sets the streaming mark. A streaming hit sets the streaming mark only on a line that is not persisting, and leaves a persisting line as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup strobe |
| reqAddr | input | 12 | Line address: low 2 bits select the set, upper 10 bits are the tag |
| reqProp | input | 2 | Access property: 00 normal, 01 streaming, 10 persisting, 11 normal |
| resvWays | input | 3 | Number of reserved ways per set |
| tenantDisable | input | 1 | Forces the reserved region to zero ways |
| persistClear | input | 1 | Clears every persisting mark |
| ageTick | input | 1 | Age decrement pulse |
| rspValid | output | 1 | Response strobe, one cycle after the lookup |
| rspHit | output | 1 | Lookup hit |
| rspWay | output | 3 | Hit way or victim way |

## Verification
Every result arrives one clock after the edge that takes the lookup. Every state change made by that edge (fill, mark update, age step, clear) is seen by a lookup at the very next edge. The bench drives inputs on the falling edge and runs its reference model as if at the next rising edge. It compares `rspValid`, `rspHit` and `rspWay` at the falling edge that follows, one cycle per stimulus. Hidden state such as marks and ages is judged only through which way later misses pick.

// File: rtl/persist_dir_pkg.sv
package persist_dir_pkg;
  localparam int WAYS    = 8;
  localparam int SETS    = 4;
  localparam int ADDR_W  = 12;
  localparam int AGE_W   = 4;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int SET_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - SET_W;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  typedef enum logic [1:0] {
    PROP_NORMAL  = 2'b00,
    PROP_STREAM  = 2'b01,
    PROP_PERSIST = 2'b10,
    PROP_ALT     = 2'b11
  } prop_e;

  typedef struct packed {
    logic             write;
    logic             fill;
    logic [WAY_W-1:0] way;
    logic [SET_W-1:0] set;
    logic [TAG_W-1:0] tag;
    prop_e            prop;
    logic             clear;
    logic             tick;
  } dir_cmd_t;
endpackage

// File: rtl/persist_dir_store.sv
module persist_dir_store
  import persist_dir_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SET_W-1:0]             rdSet,
  input  dir_cmd_t                     cmd,
  output logic [WAYS-1:0]              rowValid,
  output logic [WAYS-1:0]              rowPers,
  output logic [WAYS-1:0]              rowStrm,
  output logic [WAYS-1:0][TAG_W-1:0]   rowTag,
  output logic [WAYS-1:0][WAY_W-1:0]   rowRank
);
  logic             validQ [SETS][WAYS];
  logic             persQ  [SETS][WAYS];
  logic             strmQ  [SETS][WAYS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [AGE_W-1:0] ageQ   [SETS][WAYS];
  logic [WAY_W-1:0] rankQ  [SETS][WAYS];
  logic [WAY_W-1:0] touchRank;

  assign touchRank = rankQ[cmd.set][cmd.way];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rowValid[w] = validQ[rdSet][w];
      rowPers[w]  = persQ[rdSet][w];
      rowStrm[w]  = strmQ[rdSet][w];
      rowTag[w]   = tagQ[rdSet][w];
      rowRank[w]  = rankQ[rdSet][w];
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : gSet
    for (genvar w = 0; w < WAYS; w++) begin : gWay
      logic setSel, lineSel;
      assign setSel  = cmd.write && (cmd.set == SET_W'(s));
      assign lineSel = setSel && (cmd.way == WAY_W'(w));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ[s][w] <= 1'b0;
          persQ[s][w]  <= 1'b0;
          strmQ[s][w]  <= 1'b0;
          tagQ[s][w]   <= '0;
          ageQ[s][w]   <= '0;
          rankQ[s][w]  <= WAY_W'(w);
        end else begin
          if (lineSel) begin
            ageQ[s][w] <= AGE_MAX;
            if (cmd.fill) begin
              validQ[s][w] <= 1'b1;
              tagQ[s][w]   <= cmd.tag;
              persQ[s][w]  <= (cmd.prop == PROP_PERSIST);
              strmQ[s][w]  <= (cmd.prop == PROP_STREAM);
            end else begin
              case (cmd.prop)
                PROP_PERSIST: begin persQ[s][w] <= 1'b1; strmQ[s][w] <= 1'b0; end
                PROP_STREAM:  if (!persQ[s][w]) strmQ[s][w] <= 1'b1;
                default:      begin persQ[s][w] <= 1'b0; strmQ[s][w] <= 1'b0; end
              endcase
            end
          end else if (cmd.tick && persQ[s][w]) begin
            if (ageQ[s][w] <= AGE_W'(1)) begin
              persQ[s][w] <= 1'b0;
              ageQ[s][w]  <= '0;
            end else begin
              ageQ[s][w] <= ageQ[s][w] - AGE_W'(1);
            end
          end
          if (cmd.clear) persQ[s][w] <= 1'b0;
          if (setSel) begin
            if (lineSel)                       rankQ[s][w] <= '0;
            else if (rankQ[s][w] < touchRank)  rankQ[s][w] <= rankQ[s][w] + WAY_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/persist_dir_ctrl.sv
module persist_dir_ctrl
  import persist_dir_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [1:0]                   reqProp,
  input  logic [WAY_W-1:0]             resvWays,
  input  logic                         tenantDisable,
  input  logic                         persistClear,
  input  logic                         ageTick,
  input  logic [WAYS-1:0]              rowValid,
  input  logic [WAYS-1:0]              rowPers,
  input  logic [WAYS-1:0]              rowStrm,
  input  logic [WAYS-1:0][TAG_W-1:0]   rowTag,
  input  logic [WAYS-1:0][WAY_W-1:0]   rowRank,
  output dir_cmd_t                     cmd,
  output logic                         rspValid,
  output logic                         rspHit,
  output logic [WAY_W-1:0]             rspWay
);
  logic [TAG_W-1:0] reqTag;
  logic [WAY_W-1:0] effResv, hitWay, victim, bestRank;
  logic [WAYS-1:0]  hitVec, resvMask, candMask, invMask, strmMask, normMask, persMask, pool;
  logic             hit, persReq, invFound, poolFound;

  assign reqTag  = reqAddr[ADDR_W-1:SET_W];
  assign effResv = tenantDisable ? '0 : resvWays;
  assign persReq = (reqProp == PROP_PERSIST);

  for (genvar w = 0; w < WAYS; w++) begin : gMask
    assign hitVec[w]   = rowValid[w] && (rowTag[w] == reqTag);
    assign resvMask[w] = (WAY_W'(w) < effResv);
  end

  assign hit      = |hitVec;
  assign candMask = (persReq && effResv != '0) ? resvMask : ~(resvMask & rowPers);
  assign invMask  = candMask & ~rowValid;
  assign strmMask = candMask & rowValid & rowStrm;
  assign normMask = candMask & rowValid & ~rowStrm & ~rowPers;
  assign persMask = candMask & rowValid & rowPers;
  assign pool     = (|strmMask) ? strmMask : ((|normMask) ? normMask : persMask);

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end

  always_comb begin
    victim    = '0;
    bestRank  = '0;
    invFound  = 1'b0;
    poolFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!invFound && invMask[w]) begin
        victim   = WAY_W'(w);
        invFound = 1'b1;
      end
    end
    if (!invFound) begin
      for (int w = 0; w < WAYS; w++) begin
        if (pool[w] && (!poolFound || rowRank[w] > bestRank)) begin
          victim    = WAY_W'(w);
          bestRank  = rowRank[w];
          poolFound = 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd.write = reqValid;
    cmd.fill  = !hit;
    cmd.way   = hit ? hitWay : victim;
    cmd.set   = reqAddr[SET_W-1:0];
    cmd.tag   = reqTag;
    cmd.prop  = prop_e'(reqProp);
    cmd.clear = persistClear;
    cmd.tick  = ageTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspWay   <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= reqValid && hit;
      rspWay   <= reqValid ? cmd.way : '0;
    end
  end
endmodule

// File: rtl/persist_dir.sv
module persist_dir
  import persist_dir_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqProp,
  input  logic [WAY_W-1:0]  resvWays,
  input  logic              tenantDisable,
  input  logic              persistClear,
  input  logic              ageTick,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay
);
  dir_cmd_t                   cmd;
  logic [WAYS-1:0]            rowValid, rowPers, rowStrm;
  logic [WAYS-1:0][TAG_W-1:0] rowTag;
  logic [WAYS-1:0][WAY_W-1:0] rowRank;

  persist_dir_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqProp(reqProp),
    .resvWays(resvWays), .tenantDisable(tenantDisable), .persistClear(persistClear),
    .ageTick(ageTick), .rowValid(rowValid), .rowPers(rowPers), .rowStrm(rowStrm),
    .rowTag(rowTag), .rowRank(rowRank), .cmd(cmd), .rspValid(rspValid),
    .rspHit(rspHit), .rspWay(rspWay)
  );

  persist_dir_store u_store (
    .clk(clk), .rstN(rstN), .rdSet(reqAddr[SET_W-1:0]), .cmd(cmd),
    .rowValid(rowValid), .rowPers(rowPers), .rowStrm(rowStrm),
    .rowTag(rowTag), .rowRank(rowRank)
  );
endmodule

// File: rtl/persist_dir_chk.sv
module persist_dir_chk
  import persist_dir_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqProp,
  input logic [WAY_W-1:0]  resvWays,
  input logic              tenantDisable,
  input logic              persistClear,
  input logic              rspValid,
  input logic              rspHit,
  input logic [WAY_W-1:0]  rspWay,
  input logic [WAYS-1:0]   rowPers
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_quiet_without_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspHit));

  assert_repeat_hits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(reqValid) && reqAddr == $past(reqAddr))
      |=> (rspHit && rspWay == $past(rspWay)));

  assert_persist_in_reserve_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit && $past(reqProp) == 2'b10 && !$past(tenantDisable)
      && $past(resvWays) != '0) |-> (rspWay < $past(resvWays)));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    persistClear |=> (rowPers == '0));
endmodule

bind persist_dir persist_dir_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqProp(reqProp),
  .resvWays(resvWays), .tenantDisable(tenantDisable), .persistClear(persistClear),
  .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay), .rowPers(rowPers)
);

// File: tb/persist_dir_tb.sv
module persist_dir_tb;
  import persist_dir_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0] reqProp = '0;
  logic [WAY_W-1:0] resvWays = '0;
  logic tenantDisable = 1'b0;
  logic persistClear = 1'b0;
  logic ageTick = 1'b0;
  logic rspValid, rspHit;
  logic [WAY_W-1:0] rspWay;

  int total = 0;
  int bad = 0;
  string phase = "R1 reset";

  bit mV [SETS][WAYS];
  bit mP [SETS][WAYS];
  bit mS [SETS][WAYS];
  int mTag [SETS][WAYS];
  int mAge [SETS][WAYS];
  int order [SETS][$];

  always #(CLK_PERIOD/2) clk = ~clk;

  persist_dir u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqProp(reqProp),
    .resvWays(resvWays), .tenantDisable(tenantDisable), .persistClear(persistClear),
    .ageTick(ageTick), .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay)
  );

  function automatic int recency(int s, int w);
    for (int i = 0; i < order[s].size(); i++) if (order[s][i] == w) return i;
    return 0;
  endfunction

  function automatic void touch(int s, int w);
    int i = recency(s, w);
    order[s].delete(i);
    order[s].push_front(w);
  endfunction

  function automatic void modelStep(bit v, int tg, int st, int pr, bit clr, bit tk,
                                    output bit eh, output int ew);
    int effR = tenantDisable ? 0 : int'(resvWays);
    int acc = -1;
    eh = 0; ew = 0;
    if (v) begin
      for (int w = 0; w < WAYS; w++) if (mV[st][w] && mTag[st][w] == tg) begin eh = 1; ew = w; end
      if (eh) begin
        if (pr == 2) begin mP[st][ew] = 1; mS[st][ew] = 0; end
        else if (pr == 1) begin if (!mP[st][ew]) mS[st][ew] = 1; end
        else begin mP[st][ew] = 0; mS[st][ew] = 0; end
      end else begin
        bit found = 0;
        int bestTier = 9, bestPos = -1;
        for (int w = 0; w < WAYS; w++) begin
          bit cand = (pr == 2 && effR > 0) ? (w < effR) : !(w < effR && mV[st][w] && mP[st][w]);
          if (cand && !mV[st][w] && !found) begin found = 1; ew = w; end
        end
        if (!found) begin
          for (int w = 0; w < WAYS; w++) begin
            bit cand = (pr == 2 && effR > 0) ? (w < effR) : !(w < effR && mV[st][w] && mP[st][w]);
            int tier = mS[st][w] ? 1 : (mP[st][w] ? 3 : 2);
            int pos = recency(st, w);
            if (cand && (tier < bestTier || (tier == bestTier && pos > bestPos))) begin
              bestTier = tier; bestPos = pos; ew = w;
            end
          end
        end
        mV[st][ew] = 1; mTag[st][ew] = tg;
        mP[st][ew] = (pr == 2); mS[st][ew] = (pr == 1);
      end
      mAge[st][ew] = 15;
      touch(st, ew);
      acc = ew;
    end
    if (tk)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (mP[s][w] && !(v && s == st && w == acc)) begin
            if (mAge[s][w] <= 1) begin mP[s][w] = 0; mAge[s][w] = 0; end
            else mAge[s][w]--;
          end
    if (clr)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mP[s][w] = 0;
  endfunction

  task automatic step(bit v, int tg, int st, int pr, bit clr, bit tk);
    bit eh; int ew;
    reqValid = v; reqAddr = ADDR_W'(tg * SETS + st); reqProp = 2'(pr);
    persistClear = clr; ageTick = tk;
    modelStep(v, tg, st, pr, clr, tk, eh, ew);
    @(posedge clk); @(negedge clk);
    total++;
    if (rspValid !== v || (v && (rspHit !== eh || int'(rspWay) != ew))) begin
      bad++;
      $display("FAIL %s: actual valid=%0b hit=%0b way=%0d expected valid=%0b hit=%0b way=%0d",
               phase, rspValid, rspHit, rspWay, v, eh, ew);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) order[s].push_back(w);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: actual valid=%0b hit=%0b expected valid=0 hit=0", rspValid, rspHit);
    end
    step(0, 0, 0, 0, 0, 0);

    resvWays = 3'd6;
    phase = "R3 R6 persisting fill";
    for (int t = 1; t <= 7; t++) step(1, t, 0, 2, 0, 0);
    phase = "R2 repeat hit";
    step(1, 7, 0, 2, 0, 0);
    phase = "R4 shared region only";
    step(1, 20, 0, 0, 0, 0);
    step(1, 21, 0, 0, 0, 0);
    step(1, 22, 0, 1, 0, 0);
    step(1, 23, 0, 0, 0, 0);
    phase = "R7 normal hit clears mark";
    step(1, 3, 0, 0, 0, 0);
    step(1, 24, 0, 0, 0, 0);
    step(1, 25, 0, 0, 0, 0);
    phase = "R8 global clear";
    step(0, 0, 0, 0, 1, 0);
    step(1, 26, 0, 0, 0, 0);
    step(1, 27, 0, 2, 1, 0);
    step(1, 28, 0, 0, 0, 0);

    phase = "R9 aging";
    for (int t = 1; t <= 6; t++) step(1, t, 1, 2, 0, 0);
    step(1, 30, 1, 0, 0, 0);
    step(1, 31, 1, 0, 0, 0);
    for (int i = 0; i < 13; i++) step(0, 0, 0, 0, 0, 1);
    step(1, 3, 1, 2, 0, 1);
    step(1, 32, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 33, 1, 0, 0, 0);
    step(1, 34, 1, 0, 0, 0);

    phase = "R10 disable";
    resvWays = 3'd0;
    for (int t = 1; t <= 8; t++) step(1, t, 2, 0, 0, 0);
    for (int t = 1; t <= 8; t++) if (t != 7) step(1, t, 2, 0, 0, 0);
    resvWays = 3'd6; tenantDisable = 1'b1;
    step(1, 40, 2, 2, 0, 0);
    tenantDisable = 1'b0;
    step(1, 41, 2, 2, 0, 0);

    phase = "R5 streaming first";
    resvWays = 3'd0;
    for (int t = 1; t <= 8; t++) step(1, t, 3, 0, 0, 0);
    step(1, 9, 3, 1, 0, 0);
    for (int t = 2; t <= 8; t++) step(1, t, 3, 0, 0, 0);
    step(1, 9, 3, 1, 0, 0);
    step(1, 10, 3, 0, 0, 0);
    phase = "R11 property update";
    step(1, 10, 3, 1, 0, 0);
    step(1, 11, 3, 0, 0, 0);

    phase = "R2 R11 mixed traffic";
    for (int i = 0; i < 3000; i++) begin
      if (i % 60 == 0) begin
        resvWays = 3'($urandom_range(0, 7));
        tenantDisable = ($urandom_range(0, 4) == 0);
      end
      step(($urandom_range(0, 5) != 0), $urandom_range(0, 11), $urandom_range(0, 3),
           $urandom_range(0, 3), ($urandom_range(0, 50) == 0), ($urandom_range(0, 2) == 0));
    end

    reqValid = 1'b0; persistClear = 1'b0; ageTick = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule